// File: doc/BRIEF.md
# Eight-Function Integer ALU with Condition Flags

This block is a purely combinational integer unit. It takes two operands and a three-bit function code, and it returns one result word and a five-bit condition vector. The functions are bitwise OR and AND, addition, subtraction, three shifts, and a signed less-than compare. Subtraction uses the same adder as addition: the adder is fed the inverted second operand and a carry-in of one. There is no separate subtractor or negator. The shifts take their distance from only the low bits of the second operand.

The condition vector reports five things: whether the operands are equal, signed overflow, unsigned overflow, a zero result and a negative result. The two overflow bits are live only for addition and subtraction. For every other function they are forced to zero. A surrounding datapath drives the operands and the function code. It reads the result and the flags in the same cycle and registers them where it needs them.

Top module: `octet_alu`

## Requirements
- R1: Code 3'b000 returns X|Y and code 3'b001 returns X&Y.
- R2: Code 3'b010 returns X+Y modulo 2^W, and flag bit 2 (unsigned overflow) equals the carry out of the top bit.
- R3: Code 3'b011 returns X−Y modulo 2^W, formed as X+~Y+1. Flag bit 2 is 1 exactly when Y exceeds X as unsigned numbers (a borrow).
- R4: For codes 3'b010 and 3'b011, flag bit 1 (signed overflow) is 1 exactly when the two's-complement result falls outside the W-bit signed range.
- R5: For codes 3'b000, 3'b001 and 3'b100 through 3'b111, flag bits 1 and 2 are 0.
- R6: Code 3'b100 shifts X left with zero fill. Code 3'b101 shifts X right with zero fill. Code 3'b110 shifts X right, filling with X's top bit.
- R7: The shift distance is Y[log2(W)-1:0] only. The upper bits of Y do not change the shift result.
- R8: Code 3'b111 returns 1 when X<Y as signed two's-complement numbers, and 0 otherwise.
- R9: Flag bit 0 is 1 when X equals Y, whatever the code.
- R10: Flag bit 3 is 1 when the selected result is zero. Flag bit 4 equals the top bit of the selected result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| x_in | input | W | First operand |
| y_in | input | W | Second operand; its low log2(W) bits set the shift distance |
| op_in | input | 3 | Function code |
| result_o | output | W | Selected result |
| flags_o | output | 5 | {negative, zero, unsigned overflow, signed overflow, equal} |

## Verification
The bench builds the unit at the default width of eight bits. At this width the shift field is three bits, so all eight shift distances appear. The signed range of −128 to 127 is small enough that directed operands reach both overflow edges, as well as results where both overflow bits are set and results where neither is set. Random operands are drawn with random upper bits in Y for every code. This checks that the shifts ignore those bits, while the equality flag still sees them.

// File: rtl/octet_alu_pkg.sv
package octet_alu_pkg;
  typedef enum logic [2:0] {
    OP_OR  = 3'b000,
    OP_AND = 3'b001,
    OP_ADD = 3'b010,
    OP_SUB = 3'b011,
    OP_SHL = 3'b100,
    OP_SHR = 3'b101,
    OP_SAR = 3'b110,
    OP_SLT = 3'b111
  } alu_op_e;

  localparam int OP_BITS  = 3;
  localparam int FLAG_CNT = 5;
  localparam int FLG_EQ   = 0;
  localparam int FLG_OVF  = 1;
  localparam int FLG_CRY  = 2;
  localparam int FLG_ZERO = 3;
  localparam int FLG_NEG  = 4;
endpackage

// File: rtl/octet_alu_addsub.sv
module octet_alu_addsub #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         ovf_o,
  output logic         cry_o
);
  logic [W-1:0] b_eff;
  logic         cout;

  // Subtraction reuses the adder: a + ~b + 1
  assign b_eff = sub_i ? ~b_i : b_i;
  assign {cout, sum_o} = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, sub_i};

  // Signed overflow: both addends share a sign and the sum's sign differs
  assign ovf_o = (a_i[W-1] == b_eff[W-1]) && (sum_o[W-1] != a_i[W-1]);
  // Unsigned overflow: carry for add, missing carry (borrow) for subtract
  assign cry_o = cout ^ sub_i;
endmodule

// File: rtl/octet_alu_shift.sv
module octet_alu_shift #(
  parameter int W  = 8,
  parameter int SW = $clog2(W)
) (
  input  logic [W-1:0]  d_i,
  input  logic [SW-1:0] amt_i,
  input  logic          arith_i,
  output logic [W-1:0]  left_o,
  output logic [W-1:0]  right_o
);
  logic [W-1:0] l_stage [SW+1];
  logic [W-1:0] r_stage [SW+1];
  logic         fill;

  assign fill       = arith_i & d_i[W-1];
  assign l_stage[0] = d_i;
  assign r_stage[0] = d_i;

  // Log-depth barrel: stage s moves by 2^s when amount bit s is set
  for (genvar s = 0; s < SW; s++) begin : g_stage
    localparam int STEP = 1 << s;
    assign l_stage[s+1] = amt_i[s] ? {l_stage[s][W-1-STEP:0], {STEP{1'b0}}}
                                   : l_stage[s];
    assign r_stage[s+1] = amt_i[s] ? {{STEP{fill}}, r_stage[s][W-1:STEP]}
                                   : r_stage[s];
  end

  assign left_o  = l_stage[SW];
  assign right_o = r_stage[SW];
endmodule

// File: rtl/octet_alu_flags.sv
module octet_alu_flags
  import octet_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0]        x_i,
  input  logic [W-1:0]        y_i,
  input  logic [W-1:0]        res_i,
  input  logic                arith_i,
  input  logic                ovf_i,
  input  logic                cry_i,
  output logic [FLAG_CNT-1:0] flags_o
);
  always_comb begin
    flags_o           = '0;
    flags_o[FLG_EQ]   = (x_i == y_i);
    flags_o[FLG_OVF]  = arith_i & ovf_i;
    flags_o[FLG_CRY]  = arith_i & cry_i;
    flags_o[FLG_ZERO] = ~|res_i;
    flags_o[FLG_NEG]  = res_i[W-1];
  end
endmodule

// File: rtl/octet_alu.sv
module octet_alu
  import octet_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0]        x_in,
  input  logic [W-1:0]        y_in,
  input  logic [OP_BITS-1:0]  op_in,
  output logic [W-1:0]        result_o,
  output logic [FLAG_CNT-1:0] flags_o
);
  localparam int SW = $clog2(W);

  alu_op_e      op;
  logic [W-1:0] sum, shl, shr;
  logic         ovf, cry, is_arith, less;

  assign op       = alu_op_e'(op_in);
  assign is_arith = (op == OP_ADD) || (op == OP_SUB);

  // One adder serves add, subtract and the signed compare
  octet_alu_addsub #(.W(W)) u_addsub (
    .a_i   (x_in),
    .b_i   (y_in),
    .sub_i (op != OP_ADD),
    .sum_o (sum),
    .ovf_o (ovf),
    .cry_o (cry)
  );

  octet_alu_shift #(.W(W), .SW(SW)) u_shift (
    .d_i     (x_in),
    .amt_i   (y_in[SW-1:0]),
    .arith_i (op == OP_SAR),
    .left_o  (shl),
    .right_o (shr)
  );

  // x < y signed: sign of x - y corrected by overflow
  assign less = sum[W-1] ^ ovf;

  always_comb begin
    unique case (op)
      OP_OR:   result_o = x_in | y_in;
      OP_AND:  result_o = x_in & y_in;
      OP_ADD:  result_o = sum;
      OP_SUB:  result_o = sum;
      OP_SHL:  result_o = shl;
      OP_SHR:  result_o = shr;
      OP_SAR:  result_o = shr;
      OP_SLT:  result_o = {{(W-1){1'b0}}, less};
      default: result_o = '0;
    endcase
  end

  octet_alu_flags #(.W(W)) u_flags (
    .x_i     (x_in),
    .y_i     (y_in),
    .res_i   (result_o),
    .arith_i (is_arith),
    .ovf_i   (ovf),
    .cry_i   (cry),
    .flags_o (flags_o)
  );
endmodule

// File: rtl/octet_alu_chk.sv
module octet_alu_chk
  import octet_alu_pkg::*;
#(
  parameter int W = 8
) (
  input logic [W-1:0]        x_in,
  input logic [W-1:0]        y_in,
  input logic [OP_BITS-1:0]  op_in,
  input logic [W-1:0]        result_o,
  input logic [FLAG_CNT-1:0] flags_o
);
  localparam int SW = $clog2(W);

  always_comb begin
    if (!$isunknown({x_in, y_in, op_in, result_o, flags_o})) begin
      // R5: overflow bits idle outside add/subtract
      p_no_overflow_r5: assert (op_in == OP_ADD || op_in == OP_SUB ||
                                (!flags_o[FLG_OVF] && !flags_o[FLG_CRY]));
      // R4: signed overflow on add needs like-signed operands and a sign flip
      p_add_ovf_sign_r4: assert (!(op_in == OP_ADD && flags_o[FLG_OVF]) ||
                                 (x_in[W-1] == y_in[W-1] &&
                                  result_o[W-1] != x_in[W-1]));
      // R3: equal operands subtract to zero without borrow
      p_sub_self_r3: assert (!(op_in == OP_SUB && x_in == y_in) ||
                             (result_o == '0 && !flags_o[FLG_CRY]));
      // R8: compare result is a single bit
      p_slt_bit_r8: assert (op_in != OP_SLT || result_o[W-1:1] == '0);
      // R6: a nonzero left shift clears bit 0
      p_shl_fill_r6: assert (!(op_in == OP_SHL && y_in[SW-1:0] != '0) ||
                             !result_o[0]);
      // R10: zero flag and negative flag are exclusive
      p_zero_neg_r10: assert (!(flags_o[FLG_ZERO] && flags_o[FLG_NEG]));
      // R9: OR of equal operands returns the operand itself
      p_eq_or_r9: assert (!(op_in == OP_OR && flags_o[FLG_EQ]) ||
                          result_o == x_in);
    end
  end
endmodule

bind octet_alu octet_alu_chk #(.W(W)) u_chk (
  .x_in     (x_in),
  .y_in     (y_in),
  .op_in    (op_in),
  .result_o (result_o),
  .flags_o  (flags_o)
);

// File: tb/octet_alu_test.sv
module octet_alu_test;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] x, y;
  logic [2:0]   op;
  logic [W-1:0] res;
  logic [4:0]   flg;
  int           checks = 0;
  int           bad    = 0;
  bit           done   = 1'b0;

  always #2.5 clk = ~clk;

  octet_alu #(.W(W)) uut (
    .x_in(x), .y_in(y), .op_in(op), .result_o(res), .flags_o(flg)
  );

  function automatic string op_tag(input logic [2:0] o);
    case (o)
      3'd0, 3'd1: return "R1";
      3'd2:       return "R2";
      3'd3:       return "R3";
      3'd4, 3'd5, 3'd6: return "R6";
      default:    return "R8";
    endcase
  endfunction

  function automatic logic [W-1:0] ref_res(input logic [W-1:0] a, b,
                                           input logic [2:0] o);
    int sh;
    sh = int'(b[2:0]);
    case (o)
      3'd0: return a | b;
      3'd1: return a & b;
      3'd2: return W'(int'(a) + int'(b));
      3'd3: return W'(int'(a) - int'(b));
      3'd4: return a << sh;
      3'd5: return a >> sh;
      3'd6: return W'($signed(a) >>> sh);
      default: return ($signed(a) < $signed(b)) ? W'(1) : W'(0);
    endcase
  endfunction

  function automatic logic ref_ovf(input logic [W-1:0] a, b, input logic [2:0] o);
    int r;
    if (o == 3'd2) r = int'($signed(a)) + int'($signed(b));
    else if (o == 3'd3) r = int'($signed(a)) - int'($signed(b));
    else return 1'b0;
    return (r > 127) || (r < -128);
  endfunction

  function automatic logic ref_cry(input logic [W-1:0] a, b, input logic [2:0] o);
    if (o == 3'd2) return (int'(a) + int'(b)) > 255;
    if (o == 3'd3) return int'(b) > int'(a);
    return 1'b0;
  endfunction

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h (x=%0h y=%0h op=%0d)",
               tag, what, act, exp, x, y, op);
    end
  endtask

  task automatic run(input logic [W-1:0] a, b, input logic [2:0] o);
    logic [W-1:0] er;
    @(negedge clk);
    x = a; y = b; op = o;
    @(posedge clk); #1;
    er = ref_res(a, b, o);
    chk(op_tag(o), "result", int'(res), int'(er));
    chk("R9", "eq", int'(flg[0]), int'(a == b));
    chk((o == 3'd2 || o == 3'd3) ? "R4" : "R5", "ovf", int'(flg[1]), int'(ref_ovf(a, b, o)));
    chk(o == 3'd2 ? "R2" : (o == 3'd3 ? "R3" : "R5"), "cry", int'(flg[2]),
        int'(ref_cry(a, b, o)));
    chk("R10", "zero", int'(flg[3]), int'(er == '0));
    chk("R10", "neg", int'(flg[4]), int'(er[W-1]));
  endtask

  initial begin
    logic [W-1:0] keep;
    int seed_dummy;
    x = '0; y = '0; op = '0;
    seed_dummy = $urandom(32'h5eed1234);
    repeat (3) @(posedge clk);
    rst = 1'b0;
    #1;
    // reset/idle state: zero operands, OR
    chk("R10", "idle zero flag", int'(flg), 5'b01001);
    chk("R1", "idle result", int'(res), 0);

    // directed corners
    run(8'h00, 8'h01, 3'd3);   // borrow, no signed overflow
    run(8'h41, 8'h41, 3'd2);   // signed overflow only
    run(8'h80, 8'h80, 3'd2);   // both overflow bits, zero result
    run(8'h80, 8'h01, 3'd3);   // signed overflow on subtract
    run(8'h7f, 8'hff, 3'd3);   // both on subtract
    run(8'h12, 8'h34, 3'd2);   // neither
    run(8'h55, 8'h55, 3'd3);
    run(8'hf0, 8'h0f, 3'd0);
    run(8'hf0, 8'h3c, 3'd1);
    run(8'h80, 8'h7f, 3'd7);
    run(8'h7f, 8'h80, 3'd7);
    run(8'hff, 8'hff, 3'd7);
    for (int s = 0; s < 8; s++) begin
      run(8'h96, 8'(s), 3'd4);
      run(8'h96, 8'(s), 3'd5);
      run(8'h96, 8'(s), 3'd6);
    end
    // R7: upper bits of Y must not change a shift
    for (int o = 4; o <= 6; o++) begin
      run(8'hb3, 8'h04, 3'(o));
      keep = res;
      run(8'hb3, 8'h54, 3'(o));
      chk("R7", "upper shift bits ignored", int'(res), int'(keep));
    end
    // random sweep over every code
    for (int i = 0; i < 3000; i++) begin
      run(W'($urandom), W'($urandom), 3'(i % 8));
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule